// File: doc/BRIEF.md
# Dual-Channel Management Access Arbiter

This block sits between software and a serial management frame engine. Software owns two request channels. Each channel holds a PHY address, a PHY register address, a 16-bit data word and a direction flag. Setting a channel's go bit hands the request to hardware. The arbiter then launches pending requests one at a time on the single frame engine. When the engine reports the end of a frame, the arbiter retires the request. Retiring a request clears its go bit, stores any read result and raises a per-channel completion flag.

When both channels are waiting, a round-robin pointer picks between them, so neither channel can starve. Completion flags are gated by a per-channel enable. Software sets that enable through one address and clears it through another. A single interrupt line reports any flag that is both raised and enabled. While any request is waiting or in flight, a pause output holds the background link poller off the bus. The engine's ready input tells the arbiter when the bus is free to take a user frame.

Top module: `uaa_user_access`

## Requirements
- R1: While reset is high and on the first cycle after it, eng_req, irq and poll_pause are low. Both channel words, the raw flags and the enable mask read back as zero.
- R2: A channel word (channel 0 at address 0, channel 1 at address 1) has go at bit 31, write at bit 30, a read-only acknowledge at bit 29, the PHY address at [25:21], the register address at [20:16] and data at [15:0]. A write to an idle channel loads all fields and clears acknowledge. If go is 1 and eng_ready is high, eng_req is high from the next clock edge after the edge that took the write, and eng_write, eng_phy, eng_regad and eng_wdata carry that channel's fields.
- R3: On the edge that samples eng_done with eng_req high, the served channel's go bit clears, its raw flag sets and eng_req falls.
- R4: When a read completes, eng_rdata is stored in the data field and eng_ack is stored in the acknowledge bit. A completed write leaves data unchanged and acknowledge at 0.
- R5: While a channel's go bit is set, writes to that channel's word are ignored, and this includes a write with go=0.
- R6: When both channels are pending at launch, the channel named by the round-robin pointer wins. The pointer is 0 after reset and moves to the other channel after every grant.
- R7: A single pending channel is granted whatever the pointer value. No request launches while eng_ready is low.
- R8: Raw completion flags read at address 2 (bit 0 for channel 0, bit 1 for channel 1). Writing 1 to a bit clears that flag and writing 0 has no effect. A completion on the same edge as a clear leaves the flag set.
- R9: Writing 1s to address 4 enables those channels and writing 1s to address 5 disables them; 0 bits change nothing. Both addresses read back the mask. Address 3 reads raw AND mask.
- R10: irq equals the OR of raw AND mask, one clock after that value changes.
- R11: poll_pause is high exactly while at least one channel's go bit is set.
- R12: eng_req and its field outputs stay stable until eng_done. Only one request is in flight at a time, and eng_done is ignored while eng_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| eng_ready | input | 1 | Frame engine can take a user frame |
| eng_req | output | 1 | Request in flight to the frame engine |
| eng_write | output | 1 | Request direction, 1 = write |
| eng_phy | output | 5 | PHY address of the request |
| eng_regad | output | 5 | PHY register address of the request |
| eng_wdata | output | 16 | Data to write |
| eng_done | input | 1 | One-cycle end-of-frame pulse |
| eng_ack | input | 1 | PHY answered the read |
| eng_rdata | input | 16 | Data returned by a read |
| poll_pause | output | 1 | Holds the link poller off the bus |
| irq | output | 1 | Masked completion interrupt |

## Verification
Each result has a fixed latency. A register read shows up on reg_rdata after the edge that samples reg_rd_en. A go write shows eng_req one edge after the write edge. Go clear, the raw flag and the read result are due on the eng_done edge itself. irq follows one edge later. The bench drives every stimulus at the falling edge and samples only at falling edges. It checks exactly those cycles, including the cycle before each expected change, so a result that arrives one edge early or late is caught. A bench model of the round-robin pointer predicts the grant order. That order is checked through the PHY address on the engine outputs.

// File: rtl/uaa_pkg.sv
package uaa_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int WORD_W = 32;
  localparam int GO_BIT  = 31;
  localparam int WR_BIT  = 30;
  localparam int ACK_BIT = 29;

  localparam logic [ADDR_W-1:0] A_CH0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CH1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RAW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MSET = 3'd4;
  localparam logic [ADDR_W-1:0] A_MCLR = 3'd5;

  typedef enum logic {ARB_IDLE, ARB_BUSY} arb_state_t;
endpackage

// File: rtl/uaa_chan.sv
module uaa_chan #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_go,
  input  logic              load_write,
  input  logic [PHY_W-1:0]  load_phy,
  input  logic [REG_W-1:0]  load_reg,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fin,
  input  logic              rsp_ack,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              go,
  output logic              write,
  output logic              ack,
  output logic [PHY_W-1:0]  phy,
  output logic [REG_W-1:0]  regad,
  output logic [DATA_W-1:0] data
);
  // Fields are frozen while go is set; only completion touches them then.
  always_ff @(posedge clk) begin
    if (rst) begin
      go    <= 1'b0;
      write <= 1'b0;
      ack   <= 1'b0;
      phy   <= '0;
      regad <= '0;
      data  <= '0;
    end else if (fin) begin
      go <= 1'b0;
      if (!write) begin
        data <= rsp_data;
        ack  <= rsp_ack;
      end
    end else if (load_en && !go) begin
      go    <= load_go;
      write <= load_write;
      ack   <= 1'b0;
      phy   <= load_phy;
      regad <= load_reg;
      data  <= load_data;
    end
  end
endmodule

// File: rtl/uaa_arb.sv
module uaa_arb
  import uaa_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  input  logic           eng_ready,
  input  logic           eng_done,
  output logic           busy,
  output logic           launch,
  output logic           pick,
  output logic [NCH-1:0] fin
);
  arb_state_t st;
  logic       ptr;
  logic       cur;

  always_comb begin
    pick   = (pend[0] && pend[1]) ? ptr : pend[1];
    launch = (st == ARB_IDLE) && (|pend) && eng_ready;
  end

  assign busy = (st == ARB_BUSY);

  for (genvar i = 0; i < NCH; i++) begin : g_fin
    assign fin[i] = busy && eng_done && (cur == 1'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ARB_IDLE;
      ptr <= 1'b0;
      cur <= 1'b0;
    end else begin
      case (st)
        ARB_IDLE: if (launch) begin
          st  <= ARB_BUSY;
          cur <= pick;
          ptr <= ~pick;
        end
        ARB_BUSY: if (eng_done) st <= ARB_IDLE;
        default:  st <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uaa_irq.sv
module uaa_irq
  import uaa_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] fin,
  input  logic [NCH-1:0] raw_clr,
  input  logic [NCH-1:0] mask_set,
  input  logic [NCH-1:0] mask_clr,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] mask,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      raw  <= (raw & ~raw_clr) | fin;
      mask <= (mask | mask_set) & ~mask_clr;
      irq  <= |(raw & mask);
    end
  end
endmodule

// File: rtl/uaa_user_access.sv
module uaa_user_access
  import uaa_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              eng_ready,
  output logic              eng_req,
  output logic              eng_write,
  output logic [PHY_W-1:0]  eng_phy,
  output logic [REG_W-1:0]  eng_regad,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              poll_pause,
  output logic              irq
);
  localparam int REG_LSB = DATA_W;
  localparam int PHY_LSB = DATA_W + REG_W;
  localparam int FIELD_W = PHY_W + REG_W + DATA_W;

  logic [NCH-1:0]    ch_go, ch_wr, ch_ack, ch_hit;
  logic [PHY_W-1:0]  ch_phy  [NCH];
  logic [REG_W-1:0]  ch_reg  [NCH];
  logic [DATA_W-1:0] ch_data [NCH];
  logic [WORD_W-1:0] ch_word [NCH];
  logic [NCH-1:0]    fin, raw, mask, raw_clr, mask_set, mask_clr;
  logic              busy, launch, pick;
  logic [WORD_W-1:0] rd_word;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[ACK_BIT:FIELD_W];

  function automatic logic [WORD_W-1:0] pack_word(
    input logic go, input logic wr, input logic ak,
    input logic [PHY_W-1:0] p, input logic [REG_W-1:0] r,
    input logic [DATA_W-1:0] d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[GO_BIT]  = go;
    w[WR_BIT]  = wr;
    w[ACK_BIT] = ak;
    w[PHY_LSB +: PHY_W] = p;
    w[REG_LSB +: REG_W] = r;
    w[DATA_W-1:0] = d;
    return w;
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_hit[i] = reg_wr_en && (reg_addr == ADDR_W'(i));

    uaa_chan #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .load_en    (ch_hit[i]),
      .load_go    (reg_wdata[GO_BIT]),
      .load_write (reg_wdata[WR_BIT]),
      .load_phy   (reg_wdata[PHY_LSB +: PHY_W]),
      .load_reg   (reg_wdata[REG_LSB +: REG_W]),
      .load_data  (reg_wdata[DATA_W-1:0]),
      .fin        (fin[i]),
      .rsp_ack    (eng_ack),
      .rsp_data   (eng_rdata),
      .go         (ch_go[i]),
      .write      (ch_wr[i]),
      .ack        (ch_ack[i]),
      .phy        (ch_phy[i]),
      .regad      (ch_reg[i]),
      .data       (ch_data[i])
    );

    assign ch_word[i] = pack_word(ch_go[i], ch_wr[i], ch_ack[i],
                                  ch_phy[i], ch_reg[i], ch_data[i]);
  end

  uaa_arb u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (ch_go),
    .eng_ready (eng_ready),
    .eng_done  (eng_done),
    .busy      (busy),
    .launch    (launch),
    .pick      (pick),
    .fin       (fin)
  );

  always_comb begin
    raw_clr  = (reg_wr_en && reg_addr == A_RAW)  ? reg_wdata[NCH-1:0] : '0;
    mask_set = (reg_wr_en && reg_addr == A_MSET) ? reg_wdata[NCH-1:0] : '0;
    mask_clr = (reg_wr_en && reg_addr == A_MCLR) ? reg_wdata[NCH-1:0] : '0;
  end

  uaa_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .fin      (fin),
    .raw_clr  (raw_clr),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .raw      (raw),
    .mask     (mask),
    .irq      (irq)
  );

  assign eng_req    = busy;
  assign poll_pause = |ch_go;

  // Engine fields are captured once at launch and held for the whole frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_write <= 1'b0;
      eng_phy   <= '0;
      eng_regad <= '0;
      eng_wdata <= '0;
    end else if (launch) begin
      eng_write <= ch_wr[pick];
      eng_phy   <= ch_phy[pick];
      eng_regad <= ch_reg[pick];
      eng_wdata <= ch_data[pick];
    end
  end

  always_comb begin
    rd_word = '0;
    case (reg_addr)
      A_CH0:  rd_word = ch_word[0];
      A_CH1:  rd_word = ch_word[1];
      A_RAW:  rd_word[NCH-1:0] = raw;
      A_MSK:  rd_word[NCH-1:0] = raw & mask;
      A_MSET: rd_word[NCH-1:0] = mask;
      A_MCLR: rd_word[NCH-1:0] = mask;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/uaa_user_access_chk.sv
module uaa_user_access_chk #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              eng_req,
  input logic              eng_done,
  input logic              eng_ready,
  input logic              eng_write,
  input logic [PHY_W-1:0]  eng_phy,
  input logic [REG_W-1:0]  eng_regad,
  input logic [DATA_W-1:0] eng_wdata,
  input logic              poll_pause,
  input logic              irq,
  input logic [1:0]        go_vec,
  input logic [1:0]        fin_vec
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!eng_req && !irq && !poll_pause));

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> eng_req);

  a_r12_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> ($stable(eng_phy) && $stable(eng_regad)
                                && $stable(eng_write) && $stable(eng_wdata)));

  a_r12_one_retire: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fin_vec));

  a_r3_req_drop: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done) |=> !eng_req);

  a_r3_go_clear0: assert property (@(posedge clk) disable iff (rst)
    fin_vec[0] |=> !go_vec[0]);

  a_r3_go_clear1: assert property (@(posedge clk) disable iff (rst)
    fin_vec[1] |=> !go_vec[1]);

  a_r5_go_sticky0: assert property (@(posedge clk) disable iff (rst)
    (go_vec[0] && !fin_vec[0]) |=> go_vec[0]);

  a_r5_go_sticky1: assert property (@(posedge clk) disable iff (rst)
    (go_vec[1] && !fin_vec[1]) |=> go_vec[1]);

  a_r7_launch_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_req) |-> $past(eng_ready));

  a_r11_pause_covers: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> poll_pause);
endmodule

bind uaa_user_access uaa_user_access_chk #(
  .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .eng_req    (eng_req),
  .eng_done   (eng_done),
  .eng_ready  (eng_ready),
  .eng_write  (eng_write),
  .eng_phy    (eng_phy),
  .eng_regad  (eng_regad),
  .eng_wdata  (eng_wdata),
  .poll_pause (poll_pause),
  .irq        (irq),
  .go_vec     (ch_go),
  .fin_vec    (fin)
);

// File: tb/uaa_user_access_tb.sv
module uaa_user_access_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en, reg_rd_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eng_ready, eng_req, eng_write, eng_done, eng_ack;
  logic [4:0]  eng_phy, eng_regad;
  logic [15:0] eng_wdata, eng_rdata;
  logic        poll_pause, irq;

  int n_tot = 0;
  int n_bad = 0;
  int exp_ptr = 0;

  always #4 clk = ~clk;

  uaa_user_access u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_ready(eng_ready), .eng_req(eng_req), .eng_write(eng_write),
    .eng_phy(eng_phy), .eng_regad(eng_regad), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
    .poll_pause(poll_pause), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic go, input logic w, input logic ak,
                                      input logic [4:0] p, input logic [4:0] r,
                                      input logic [15:0] d);
    return {go, w, ak, 3'b000, p, r, d};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_req();
    int n = 0;
    while (!eng_req && n < 50) begin @(negedge clk); n++; end
    if (!eng_req) chk("R2 request never raised", 32'(eng_req), 32'd1);
  endtask

  task automatic finish_req(input logic [15:0] rdat, input logic ak);
    eng_done = 1'b1; eng_rdata = rdat; eng_ack = ak;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // Wait for a launch, confirm which channel won by its PHY address, retire it.
  task automatic serve_one(input int ch, input logic [4:0] p, input logic [4:0] r);
    wait_req();
    chk($sformatf("R6 R7 grant phy ch%0d", ch), 32'(eng_phy), 32'(p));
    chk("R2 grant regad", 32'(eng_regad), 32'(r));
    exp_ptr = 1 - ch;
    finish_req(16'h0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
    eng_ready = 1'b1; eng_done = 0; eng_ack = 0; eng_rdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", 32'(eng_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req", 32'(eng_req), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pause", 32'(poll_pause), 0);
    rd(3'd0, v); chk("R1 ch0 word", v, 0);
    rd(3'd1, v); chk("R1 ch1 word", v, 0);
    rd(3'd2, v); chk("R1 raw", v, 0);
    rd(3'd4, v); chk("R1 mask", v, 0);

    // Sweep: channel x direction x PHY answer, with full timing checks
    for (int i = 0; i < 8; i++) begin
      int ch = i / 4;
      logic w = 1'(i / 2);
      logic a = 1'(i);
      logic [4:0] p = 5'(i * 3 + 1);
      logic [4:0] r = 5'(31 - i * 2);
      logic [15:0] d = 16'h1234 + 16'(i) * 16'h1111;
      logic [15:0] rdat = 16'hC000 | 16'(i);
      wr(3'(ch), mkw(1'b1, w, 1'b1, p, r, d));
      chk("R2 req not yet", 32'(eng_req), 0);
      chk("R11 pause on go", 32'(poll_pause), 1);
      @(negedge clk);
      chk("R2 req raised", 32'(eng_req), 1);
      chk("R2 fields", {6'b0, eng_write, eng_phy, eng_regad, eng_wdata},
          {6'b0, w, p, r, d});
      repeat (2) @(negedge clk);
      chk("R12 req held", 32'(eng_req), 1);
      exp_ptr = 1 - ch;
      finish_req(rdat, a);
      chk("R3 req dropped", 32'(eng_req), 0);
      chk("R11 pause off", 32'(poll_pause), 0);
      rd(3'(ch), v);
      chk("R3 R4 word after completion", v,
          mkw(1'b0, w, w ? 1'b0 : a, p, r, w ? d : rdat));
      rd(3'd2, v); chk("R3 raw set", v, 32'(1 << ch));
      chk("R9 irq masked off", 32'(irq), 0);
      wr(3'd2, 32'd0); rd(3'd2, v); chk("R8 zero write keeps raw", v, 32'(1 << ch));
      wr(3'd2, 32'(1 << ch)); rd(3'd2, v); chk("R8 raw cleared", v, 0);
    end

    // R5: writes during go are ignored, go=0 does not cancel
    wr(3'd0, mkw(1'b1, 1'b0, 1'b0, 5'd7, 5'd9, 16'h55AA));
    wait_req();
    wr(3'd0, mkw(1'b0, 1'b1, 1'b0, 5'd2, 5'd3, 16'hFFFF));
    rd(3'd0, v); chk("R5 word unchanged", v, mkw(1'b1, 1'b0, 1'b0, 5'd7, 5'd9, 16'h55AA));
    chk("R5 still requesting", 32'(eng_req), 1);
    chk("R5 engine phy", 32'(eng_phy), 32'd7);
    exp_ptr = 1;
    finish_req(16'h0BAD, 1'b1);
    rd(3'd0, v); chk("R4 read result", v, mkw(1'b0, 1'b0, 1'b1, 5'd7, 5'd9, 16'h0BAD));
    wr(3'd2, 32'd3);
    // R12: stray done while idle changes nothing
    finish_req(16'h7777, 1'b0);
    rd(3'd2, v); chk("R12 stray done raw", v, 0);
    rd(3'd0, v); chk("R12 stray done word", v, mkw(1'b0, 1'b0, 1'b1, 5'd7, 5'd9, 16'h0BAD));

    // R6/R7: both pending under a held-off engine, order from bench pointer model
    for (int k = 0; k < 4; k++) begin
      int first;
      logic [4:0] p0 = 5'(k), p1 = 5'(k + 16);
      eng_ready = 1'b0;
      wr(3'd0, mkw(1'b1, 1'b1, 1'b0, p0, 5'(k + 8), 16'(k)));
      wr(3'd1, mkw(1'b1, 1'b1, 1'b0, p1, 5'(k + 20), 16'(k)));
      @(negedge clk);
      chk("R7 no launch while not ready", 32'(eng_req), 0);
      eng_ready = 1'b1;
      first = exp_ptr;
      if (first == 0) begin
        serve_one(0, p0, 5'(k + 8)); serve_one(1, p1, 5'(k + 20));
      end else begin
        serve_one(1, p1, 5'(k + 20)); serve_one(0, p0, 5'(k + 8));
      end
      // single request on one channel regardless of the pointer
      wr(3'((k % 2)), mkw(1'b1, 1'b1, 1'b0, 5'd30, 5'd1, 16'h0));
      serve_one(k % 2, 5'd30, 5'd1);
      wr(3'd2, 32'd3);
    end

    // R10: irq latency
    wr(3'd4, 32'd1);
    wr(3'd0, mkw(1'b1, 1'b1, 1'b0, 5'd4, 5'd4, 16'h0));
    wait_req();
    exp_ptr = 1;
    finish_req(16'h0, 1'b0);
    chk("R10 irq not yet", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq raised", 32'(irq), 1);
    wr(3'd2, 32'd1);
    chk("R10 irq still high", 32'(irq), 1);
    @(negedge clk);
    chk("R10 irq dropped", 32'(irq), 0);

    // R8: completion and clear on the same edge, set wins
    wr(3'd1, mkw(1'b1, 1'b1, 1'b0, 5'd6, 5'd6, 16'h0));
    wait_req();
    exp_ptr = 0;
    eng_done = 1'b1; reg_wr_en = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd2;
    @(negedge clk);
    eng_done = 1'b0; reg_wr_en = 1'b0;
    rd(3'd2, v); chk("R8 set wins over clear", v, 32'd2);
    wr(3'd2, 32'd3);

    // R9/R10: sweep of mask and raw patterns
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        wr(3'd5, 32'd3);
        wr(3'd4, 32'(m));
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd0);
        rd(3'd5, v); chk("R9 mask readback", v, 32'(m));
        wr(3'd2, 32'd3);
        for (int c = 0; c < 2; c++) begin
          if (((r >> c) & 1) == 1) begin
            wr(3'(c), mkw(1'b1, 1'b1, 1'b0, 5'(c + 10), 5'd2, 16'h0));
            serve_one(c, 5'(c + 10), 5'd2);
          end
        end
        @(negedge clk);
        rd(3'd3, v); chk($sformatf("R9 masked m=%0d r=%0d", m, r), v, 32'(m & r));
        chk($sformatf("R10 irq m=%0d r=%0d", m, r), 32'(irq), 32'((m & r) != 0));
      end
    end

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule